// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers a set of interrupt request strobes (bus reset, two periodic timers, five endpoint events, a converter, general-purpose pins and a serial bus). Each strobe is held as pending until it is serviced. Among the pending requests whose enable mask bit is set, the one with the lowest vector address wins. Vector addresses are even and two apart: source 0 sits at 0x0004 and source 11 at 0x001A. The winner is shown in a read-only 8-bit vector register. The software-visible value is meaningful while the global enable is off.

When the global enable is on, a request is eligible and the core reports the end of its current instruction, the block takes the interrupt. It clears the global enable and acknowledges only the winner's pending bit. It then steps through a fixed entry sequence: ten call cycles, then five jump cycles. After that it signals the first handler cycle and presents the 16-bit vector address to fetch. The total entry latency is the instruction remainder plus fifteen cycles.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A high request strobe on source i sets its pending bit at the next clock edge. The bit stays set until that source is taken. If a strobe arrives in the same cycle as its own take, the bit stays set.
- R2: The vector register holds 2*(i+2) for the lowest-numbered eligible source i. Bit 0 reads 0, bits 4..1 carry i+2 and bits 7..5 read 0. A lower index always wins.
- R3: When no eligible request exists, the vector register reads 0x00. This is also the value out of reset.
- R4: A source with a mask bit of 0 neither shows in the vector register nor gets taken, but it stays pending. It reappears when the mask bit is set again.
- R5: A take (one-cycle take_o) happens only in a cycle where the global enable is 1, an eligible request exists, no entry is in progress and instr_done_i is 1.
- R6: On a take, ack_o is one-hot on the winner in the same cycle. The global enable reads 0 from the next cycle. Only the winner's pending bit is cleared.
- R7: entry_busy_o is 1 for the 15 cycles after a take (10 call + 5 jump). handler_start_o pulses 16 cycles after the take cycle, with vec_addr_o = 2*(i+2) for the taken source.
- R8: Counted from the first cycle a request is pending, with the core finishing its instruction after a remainder of r cycles, the handler starts after r+15 cycles: 16 for r=1 and 20 for r=5.
- R9: A request arriving during the entry sequence is not taken then. It stays pending and is taken once the enable is set again.
- R10: gie_set_i sets the global enable and gie_clr_i clears it. When both are high, clear wins.
- R11: With the global enable at 0, instr_done_i causes no take, and the vector register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 12 | Request strobes, bit i = source i |
| mask_i | input | 12 | Per-source enable, 1 = enabled |
| gie_set_i | input | 1 | Set the global interrupt enable |
| gie_clr_i | input | 1 | Clear the global interrupt enable |
| instr_done_i | input | 1 | Current instruction finishes this cycle |
| vec_reg_o | output | 8 | Read-only vector register value |
| gie_o | output | 1 | Global interrupt enable state |
| take_o | output | 1 | Interrupt taken this cycle |
| ack_o | output | 12 | One-hot pending-clear acknowledge |
| entry_busy_o | output | 1 | Call/jump entry sequence in progress |
| handler_start_o | output | 1 | First handler cycle |
| vec_addr_o | output | 16 | Vector address of the taken source |

## Verification
The bench builds the block with its default parameters: twelve sources, a first vector index of 2, a 10-cycle call and a 5-cycle jump. These values bring the extreme register values 0x04 and 0x1A within reach, as well as the 16- and 20-cycle latency figures for remainders of one and five cycles. The tests then probe same-cycle strobe-versus-take and set-versus-clear collisions, and requests that land in the middle of the entry sequence.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_CALL = 2'd1,
        ST_JUMP = 2'd2,
        ST_DISP = 2'd3
    } entry_state_e;

endpackage

// File: rtl/ivc_pending.sv
module ivc_pending #(
    parameter int NSRC = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] ack_i,
    output logic [NSRC-1:0] pend_o
);

    typedef struct packed {
        logic [NSRC-1:0] pend;
    } pend_t;

    pend_t st_d, st_q;

    // Set has priority over clear so a fresh strobe is never lost.
    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~ack_i) | req_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    p_req_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |=> ((pend_o & $past(req_i)) == $past(req_i)));

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ack_i) && ((req_i & ack_i) == '0)) |=> ((pend_o & $past(ack_i)) == '0));

endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
    parameter int NSRC  = 12,
    parameter int SRC_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  elig_i,
    output logic             any_o,
    output logic [NSRC-1:0]  win_oh_o,
    output logic [SRC_W-1:0] win_idx_o
);

    logic [NSRC:0] above;

    assign above[0] = 1'b0;

    // Ripple chain: a source wins only if no lower index is eligible.
    for (genvar g = 0; g < NSRC; g++) begin : g_chain
        assign win_oh_o[g]  = elig_i[g] & ~above[g];
        assign above[g + 1] = above[g] | elig_i[g];
    end

    assign any_o = above[NSRC];

    always_comb begin
        win_idx_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (win_oh_o[i]) win_idx_o = win_idx_o | SRC_W'(i);
        end
    end

endmodule

// File: rtl/ivc_entry_seq.sv
module ivc_entry_seq
    import ivc_pkg::*;
#(
    parameter int CALL_CYC = 10,
    parameter int JMP_CYC  = 5,
    parameter int SRC_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_i,
    input  logic [SRC_W-1:0] win_idx_i,
    input  logic             instr_done_i,
    input  logic             gie_set_i,
    input  logic             gie_clr_i,
    output logic             take_o,
    output logic             gie_o,
    output logic             busy_o,
    output logic             handler_o,
    output logic [SRC_W-1:0] taken_idx_o
);

    localparam int MAXC  = (CALL_CYC > JMP_CYC) ? CALL_CYC : JMP_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int GAP   = CALL_CYC + JMP_CYC + 1;
    localparam int GAP_W = $clog2(GAP + 2);

    typedef struct packed {
        entry_state_e     st;
        logic [CNT_W-1:0] cnt;
        logic             gie;
        logic [SRC_W-1:0] win;
    } seq_t;

    seq_t st_d, st_q;
    logic take;

    always_comb begin
        st_d = st_q;
        take = (st_q.st == ST_RUN) && st_q.gie && any_i && instr_done_i;

        if (gie_clr_i)      st_d.gie = 1'b0;
        else if (gie_set_i) st_d.gie = 1'b1;

        unique case (st_q.st)
            ST_RUN: begin
                if (take) begin
                    st_d.st  = ST_CALL;
                    st_d.cnt = '0;
                    st_d.gie = 1'b0;
                    st_d.win = win_idx_i;
                end
            end
            ST_CALL: begin
                if (st_q.cnt == CNT_W'(CALL_CYC - 1)) begin
                    st_d.st  = ST_JUMP;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            ST_JUMP: begin
                if (st_q.cnt == CNT_W'(JMP_CYC - 1)) begin
                    st_d.st  = ST_DISP;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            ST_DISP: begin
                st_d.st = ST_RUN;
            end
            default: st_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{st: ST_RUN, cnt: '0, gie: 1'b0, win: '0};
        else        st_q <= st_d;
    end

    assign take_o      = take;
    assign gie_o       = st_q.gie;
    assign busy_o      = (st_q.st == ST_CALL) || (st_q.st == ST_JUMP);
    assign handler_o   = (st_q.st == ST_DISP);
    assign taken_idx_o = st_q.win;

    // Independent cycle counter since the last take, for the timing check.
    logic [GAP_W-1:0] since_take_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                             since_take_q <= '0;
        else if (take)                          since_take_q <= GAP_W'(1);
        else if (since_take_q != '0 &&
                 since_take_q <= GAP_W'(GAP))   since_take_q <= since_take_q + 1'b1;
    end

    p_take_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    p_take_clears_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !gie_o);

    p_handler_timing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        handler_o |-> (since_take_q == GAP_W'(GAP)));

    p_no_take_in_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o || handler_o) |-> !take_o);

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr_i |=> !gie_o);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int NSRC      = 12,
    parameter int FIRST_VEC = 2,
    parameter int CALL_CYC  = 10,
    parameter int JMP_CYC   = 5,
    parameter int REG_W     = 8,
    parameter int ADDR_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req_i,
    input  logic [NSRC-1:0]   mask_i,
    input  logic              gie_set_i,
    input  logic              gie_clr_i,
    input  logic              instr_done_i,
    output logic [REG_W-1:0]  vec_reg_o,
    output logic              gie_o,
    output logic              take_o,
    output logic [NSRC-1:0]   ack_o,
    output logic              entry_busy_o,
    output logic              handler_start_o,
    output logic [ADDR_W-1:0] vec_addr_o
);

    localparam int SRC_W = $clog2(NSRC);
    localparam int IDX_W = $clog2(NSRC + FIRST_VEC);

    logic [NSRC-1:0]  pend, elig, win_oh;
    logic             any;
    logic [SRC_W-1:0] win_idx, taken_idx;
    logic [IDX_W-1:0] cur_vidx, taken_vidx;

    ivc_pending #(.NSRC(NSRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .ack_i  (ack_o),
        .pend_o (pend)
    );

    assign elig = pend & mask_i;

    ivc_arbiter #(.NSRC(NSRC), .SRC_W(SRC_W)) u_arb (
        .elig_i    (elig),
        .any_o     (any),
        .win_oh_o  (win_oh),
        .win_idx_o (win_idx)
    );

    ivc_entry_seq #(
        .CALL_CYC (CALL_CYC),
        .JMP_CYC  (JMP_CYC),
        .SRC_W    (SRC_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_i        (any),
        .win_idx_i    (win_idx),
        .instr_done_i (instr_done_i),
        .gie_set_i    (gie_set_i),
        .gie_clr_i    (gie_clr_i),
        .take_o       (take_o),
        .gie_o        (gie_o),
        .busy_o       (entry_busy_o),
        .handler_o    (handler_start_o),
        .taken_idx_o  (taken_idx)
    );

    assign ack_o      = take_o ? win_oh : '0;
    assign cur_vidx   = IDX_W'(win_idx) + IDX_W'(FIRST_VEC);
    assign taken_vidx = IDX_W'(taken_idx) + IDX_W'(FIRST_VEC);

    always_comb begin
        vec_reg_o = '0;
        if (any) vec_reg_o = REG_W'({cur_vidx, 1'b0});
    end

    assign vec_addr_o = ADDR_W'({taken_vidx, 1'b0});

    p_even_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_reg_o[0] == 1'b0) && (vec_reg_o[REG_W-1:IDX_W+1] == '0));

    p_empty_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & mask_i) == '0) |-> (vec_reg_o == '0));

    p_ack_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o) && (take_o == (|ack_o)));

endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;

    localparam int N = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  req_i, mask_i;
    logic          gie_set_i, gie_clr_i, instr_done_i;
    logic [7:0]    vec_reg_o;
    logic          gie_o, take_o, entry_busy_o, handler_start_o;
    logic [N-1:0]  ack_o;
    logic [15:0]   vec_addr_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_vector_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i),
        .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i), .instr_done_i(instr_done_i),
        .vec_reg_o(vec_reg_o), .gie_o(gie_o), .take_o(take_o), .ack_o(ack_o),
        .entry_busy_o(entry_busy_o), .handler_start_o(handler_start_o),
        .vec_addr_o(vec_addr_o)
    );

    function automatic logic [7:0] vreg(int i);
        return 8'((i + 2) * 2);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic pulse_req(int i);
        req_i[i] = 1'b1;
        step();
        req_i[i] = 1'b0;
    endtask

    task automatic set_gie();
        gie_set_i = 1'b1;
        step();
        gie_set_i = 1'b0;
    endtask

    // Take the current winner and let the entry sequence finish.
    task automatic take_and_drain(int src, string tag);
        instr_done_i = 1'b1;
        settle();
        chk(take_o === 1'b1, tag, take_o, 1);
        chk(ack_o === N'(1 << src), tag, ack_o, 1 << src);
        step();
        instr_done_i = 1'b0;
        repeat (16) step();
    endtask

    task automatic t_reset();
        settle();
        chk(vec_reg_o === 8'h00, "R3 reset vector", vec_reg_o, 0);
        chk(gie_o === 1'b0, "R10 reset gie", gie_o, 0);
        chk(take_o === 1'b0 && entry_busy_o === 1'b0, "R5 reset idle",
            {take_o, entry_busy_o}, 0);
    endtask

    task automatic t_priority();
        pulse_req(11);
        settle();
        chk(vec_reg_o === 8'h1A, "R2 last source", vec_reg_o, 8'h1A);
        req_i[7] = 1'b1; req_i[3] = 1'b1;
        step();
        req_i = '0;
        settle();
        chk(vec_reg_o === vreg(3), "R2 lowest wins", vec_reg_o, vreg(3));
        mask_i[3] = 1'b0;
        settle();
        chk(vec_reg_o === vreg(7), "R4 masked hidden", vec_reg_o, vreg(7));
        mask_i[3] = 1'b1;
        settle();
        chk(vec_reg_o === vreg(3), "R4 unmask reappears", vec_reg_o, vreg(3));
    endtask

    task automatic t_take();
        set_gie();
        settle();
        chk(gie_o === 1'b1, "R10 set", gie_o, 1);
        instr_done_i = 1'b1;
        settle();
        chk(take_o === 1'b1, "R5 take", take_o, 1);
        chk(ack_o === N'(1 << 3), "R6 ack winner", ack_o, 1 << 3);
        step();
        instr_done_i = 1'b0;
        settle();
        chk(gie_o === 1'b0, "R6 gie cleared", gie_o, 0);
        chk(vec_reg_o === vreg(7), "R6 others stay", vec_reg_o, vreg(7));
        for (int k = 1; k <= 15; k++) begin
            chk(entry_busy_o === 1'b1 && handler_start_o === 1'b0, "R7 busy window",
                {entry_busy_o, handler_start_o}, 2);
            step();
            settle();
        end
        chk(handler_start_o === 1'b1, "R7 handler start", handler_start_o, 1);
        chk(vec_addr_o === 16'h000A, "R7 fetch address", vec_addr_o, 16'h000A);
        step();
        settle();
        chk(entry_busy_o === 1'b0 && handler_start_o === 1'b0, "R7 back to run",
            {entry_busy_o, handler_start_o}, 0);
        set_gie();
        take_and_drain(7, "R6 take second");
        set_gie();
        take_and_drain(11, "R6 take third");
        settle();
        chk(vec_reg_o === 8'h00, "R3 drained", vec_reg_o, 0);
    endtask

    task automatic t_latency(int rem);
        int seen = -1;
        set_gie();
        pulse_req(0);
        for (int c = 0; c <= rem + 17; c++) begin
            instr_done_i = (c == rem - 1);
            settle();
            if (handler_start_o === 1'b1 && seen < 0) begin
                seen = c;
                chk(vec_addr_o === 16'h0004, "R8 first vector", vec_addr_o, 16'h0004);
            end
            step();
        end
        instr_done_i = 1'b0;
        chk(seen == rem + 15, "R8 latency", seen, rem + 15);
    endtask

    task automatic t_mid_entry();
        set_gie();
        pulse_req(5);
        take_and_drain_start();
        step(); step();
        req_i[2] = 1'b1;
        instr_done_i = 1'b1;
        settle();
        chk(take_o === 1'b0, "R9 no take in entry", take_o, 0);
        step();
        req_i = '0;
        instr_done_i = 1'b0;
        repeat (12) step();
        settle();
        chk(handler_start_o === 1'b1, "R7 handler after mid request", handler_start_o, 1);
        chk(vec_addr_o === 16'(vreg(5)), "R9 served source", vec_addr_o, vreg(5));
        step();
        settle();
        chk(vec_reg_o === vreg(2), "R9 still pending", vec_reg_o, vreg(2));
        set_gie();
        take_and_drain(2, "R9 taken later");
    endtask

    task automatic take_and_drain_start();
        instr_done_i = 1'b1;
        settle();
        chk(ack_o === N'(1 << 5), "R6 ack mid", ack_o, 1 << 5);
        step();
        instr_done_i = 1'b0;
    endtask

    task automatic t_gating();
        pulse_req(9);
        instr_done_i = 1'b1;
        for (int k = 0; k < 5; k++) begin
            settle();
            chk(take_o === 1'b0, "R11 no take gie off", take_o, 0);
            chk(vec_reg_o === vreg(9), "R1 held pending", vec_reg_o, vreg(9));
            step();
        end
        instr_done_i = 1'b0;
        gie_set_i = 1'b1; gie_clr_i = 1'b1;
        step();
        gie_set_i = 1'b0; gie_clr_i = 1'b0;
        settle();
        chk(gie_o === 1'b0, "R10 clear wins", gie_o, 0);
        mask_i[9] = 1'b0;
        set_gie();
        instr_done_i = 1'b1;
        settle();
        chk(take_o === 1'b0, "R4 masked not taken", take_o, 0);
        chk(vec_reg_o === 8'h00, "R4 masked reads zero", vec_reg_o, 0);
        step();
        instr_done_i = 1'b0;
        mask_i[9] = 1'b1;
        req_i[9] = 1'b1;
        instr_done_i = 1'b1;
        settle();
        chk(take_o === 1'b1, "R5 take after unmask", take_o, 1);
        step();
        req_i = '0;
        instr_done_i = 1'b0;
        settle();
        chk(vec_reg_o === vreg(9), "R1 strobe beats clear", vec_reg_o, vreg(9));
        repeat (16) step();
        set_gie();
        take_and_drain(9, "R6 final take");
        settle();
        chk(vec_reg_o === 8'h00, "R3 empty at end", vec_reg_o, 0);
    endtask

    initial begin
        while (cyc < 100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_i = '0; mask_i = '1;
        gie_set_i = 1'b0; gie_clr_i = 1'b0; instr_done_i = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        t_reset();
        t_priority();
        t_take();
        t_latency(1);
        t_latency(5);
        t_mid_entry();
        t_gating();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule